// File: doc/BRIEF.md
# Configuration Address Translator

This block connects a host-side pair of register windows (an index window and a data window) to an internal configuration bus. Software first stores a 32-bit index word through the index window. It then reads or writes the data window with byte, halfword or word transfers. For every data-window transfer the block builds an effective configuration address from the stored index word and the low offset bits of the transfer. It then issues exactly one request on the internal bus, carrying that address, little-endian byte enables and lane-aligned write data.

Three index layouts are recognised. When the top bit is set, the index word passes through almost unchanged. When bit 0 is set, the word is treated as an already-formatted type-1 address. Otherwise the word is a type-0 layout: the device is selected by a single IDSEL bit, and the block converts it into the usual device/function/register layout. The index and data windows each cover a 4 KiB region. The host port sees only the offset bits that matter, because window selection happens upstream.

Top module: `cfg_addr_xlate`

## Requirements
- R1: The index register resets to zero. A write through the index window (host_sel=0) stores all 32 bits of host_wdata whatever the size, and a read through the index window returns the stored word. Index accesses are acknowledged the cycle after they are accepted.
- R2: When index bit 31 is set, the internal address is index bits 31..2 followed by data offset bits 1..0.
- R3: When index bit 31 is clear and bit 0 is set, the internal address is index bits 31..3 followed by data offset bits 2..0. Bit 31 takes priority over bit 0.
- R4: When index bits 31 and 0 are both clear, the internal address has bits 31..16 zero. Bits 15..11 hold the device, which is the position of the lowest set bit among index bits 31..11, truncated to 5 bits. Bits 10..8 hold index bits 10..8 (function), bits 7..3 hold index bits 7..3, and bits 2..0 hold data offset bits 2..0.
- R5: In the layout of R4, when none of index bits 31..11 is set, the device field is 31.
- R6: host_size encodes 0=byte, 1=halfword, 2 or 3=word. The byte enables are the size mask (0001, 0011, 1111) shifted left by offset bits 1..0. Write data is shifted left by 8 times offset bits 1..0 onto the internal lanes (little-endian).
- R7: Read data from the internal bus is shifted right by 8 times the saved offset bits 1..0 and masked to the access size, with the upper bits zero.
- R8: Each data-window access (host_sel=1) produces exactly one single-cycle internal request. Index-window accesses produce none.
- R9: A data write is acknowledged the cycle after it is accepted. After a data read is accepted, host_ready stays low until cb_rvalid is seen, and host_ack follows one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host transfer request, taken when host_ready is high |
| host_sel | input | 1 | 0 = index window, 1 = data window |
| host_we | input | 1 | 1 = write, 0 = read |
| host_off | input | 3 | Low offset bits inside the selected window |
| host_size | input | 2 | Transfer size code |
| host_wdata | input | 32 | Write data, right-aligned |
| host_ready | output | 1 | Block can accept a transfer |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, right-aligned, valid with host_ack |
| cb_req | output | 1 | Internal bus request pulse |
| cb_we | output | 1 | Internal bus write flag |
| cb_addr | output | 32 | Effective configuration address |
| cb_be | output | 4 | Byte enables |
| cb_wdata | output | 32 | Lane-aligned write data |
| cb_rvalid | input | 1 | Read data valid from target |
| cb_rdata | input | 32 | Read data from target |

## Verification
A corrupted index word or a wrong format choice shows up on cb_addr in the first request after the fault, one cycle after the data access is accepted. A wrong priority search appears only in bits 15..11, so the tests pick index words whose lowest set bit sits at the edges (bit 11, bit 30, no bit at all) and words with several bits set. A stuck or misrouted control state shows at the ports as a missing or duplicated cb_req, or as host_ack arriving before cb_rvalid. Lane errors appear as wrong cb_be, shifted cb_wdata, or read data at the wrong byte position in the same transfer.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int unsigned CFG_AW   = 32;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NBYTE    = DATA_W / 8;
    localparam int unsigned LANE_W   = $clog2(NBYTE);
    localparam int unsigned OFF_W    = 3;
    localparam int unsigned IDSEL_LO = 11;
    localparam int unsigned DEV_W    = 5;
    localparam int unsigned FUNC_W   = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } xfer_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ctrl_state_e;

    typedef enum logic [1:0] {
        FMT_TYPE0 = 2'd0,
        FMT_TYPE1 = 2'd1,
        FMT_RAW   = 2'd2
    } idx_fmt_e;

    typedef struct packed {
        logic                we;
        logic [CFG_AW-1:0]   addr;
        logic [NBYTE-1:0]    be;
        logic [DATA_W-1:0]   wdata;
    } cbus_req_t;

    function automatic logic [NBYTE-1:0] size_mask(input xfer_size_e sz);
        logic [NBYTE-1:0] m;
        case (sz)
            SZ_BYTE: m = NBYTE'(1);
            SZ_HALF: m = NBYTE'(3);
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic idx_fmt_e classify(input logic [CFG_AW-1:0] idx);
        idx_fmt_e f;
        if (idx[CFG_AW-1])
            f = FMT_RAW;
        else if (idx[0])
            f = FMT_TYPE1;
        else
            f = FMT_TYPE0;
        return f;
    endfunction

endpackage

// File: rtl/cfgx_index_reg.sv
module cfgx_index_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en)
            q <= wdata;
    end

endmodule

// File: rtl/cfgx_lsb_find.sv
module cfgx_lsb_find #(
    parameter int unsigned W  = 21,
    localparam int unsigned PW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [PW-1:0] pos
);

    // Scan from the top down so the lowest set bit is the last to win.
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                pos   = PW'(i);
            end
        end
    end

endmodule

// File: rtl/cfgx_addr_decode.sv
module cfgx_addr_decode
    import cfgx_pkg::*;
#(
    parameter int unsigned AW     = CFG_AW,
    parameter int unsigned SEL_LO = IDSEL_LO,
    parameter int unsigned DVW    = DEV_W,
    parameter int unsigned FW     = FUNC_W,
    parameter int unsigned OW     = OFF_W
) (
    input  logic [AW-1:0] idx,
    input  logic [OW-1:0] off,
    output idx_fmt_e      fmt,
    output logic [AW-1:0] cfg_addr
);

    localparam int unsigned SEL_W    = AW - SEL_LO;
    localparam int unsigned PW       = (SEL_W > 1) ? $clog2(SEL_W) : 1;
    localparam int unsigned FN_LO    = SEL_LO - FW;
    localparam int unsigned DEV_LO   = FN_LO + FW;
    localparam int unsigned DEV_HI   = DEV_LO + DVW - 1;
    localparam int unsigned RAW_KEEP = 2;

    logic          sel_found;
    logic [PW-1:0] sel_pos;
    logic [DVW-1:0] dev;
    logic [AW-1:0] t0_addr;
    logic [AW-1:0] t1_addr;
    logic [AW-1:0] raw_addr;
    int            dev_full;
    logic          idx_unused_bit;

    cfgx_lsb_find #(.W(SEL_W)) u_find (
        .vec   (idx[AW-1:SEL_LO]),
        .found (sel_found),
        .pos   (sel_pos)
    );

    assign idx_unused_bit = idx[1];

    always_comb begin
        dev_full = int'(sel_pos) + int'(SEL_LO);
        dev      = sel_found ? dev_full[DVW-1:0] : '1;
    end

    always_comb begin
        t0_addr                   = '0;
        t0_addr[DEV_HI:DEV_LO]    = dev;
        t0_addr[DEV_LO-1:FN_LO]   = idx[DEV_LO-1:FN_LO];
        t0_addr[FN_LO-1:OW]       = idx[FN_LO-1:OW];
        t0_addr[OW-1:0]           = off;
    end

    assign t1_addr  = {idx[AW-1:OW], off};
    assign raw_addr = {idx[AW-1:RAW_KEEP], off[RAW_KEEP-1:0]};
    assign fmt      = classify(idx);

    always_comb begin
        case (fmt)
            FMT_RAW:   cfg_addr = raw_addr;
            FMT_TYPE1: cfg_addr = t1_addr;
            default:   cfg_addr = t0_addr;
        endcase
    end

endmodule

// File: rtl/cfgx_lane_steer.sv
module cfgx_lane_steer
    import cfgx_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    localparam int unsigned NB = DW / 8,
    localparam int unsigned LW = (NB > 1) ? $clog2(NB) : 1
) (
    input  xfer_size_e     size,
    input  logic [LW-1:0]  lane,
    input  logic [DW-1:0]  wdata_in,
    input  logic [DW-1:0]  rdata_in,
    output logic [NB-1:0]  be,
    output logic [DW-1:0]  wdata_out,
    output logic [DW-1:0]  rdata_out
);

    logic [NB-1:0] smask;
    logic [DW-1:0] bit_mask;
    logic [DW-1:0] rshift;

    assign smask = size_mask(size);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign bit_mask[8*g +: 8] = {8{smask[g]}};
    end

    assign be        = NB'(smask << lane);
    assign wdata_out = wdata_in << {lane, 3'b000};
    assign rshift    = rdata_in >> {lane, 3'b000};
    assign rdata_out = rshift & bit_mask;

endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
    import cfgx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                host_req,
    input  logic                host_sel,
    input  logic                host_we,
    input  logic [OFF_W-1:0]    host_off,
    input  logic [1:0]          host_size,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic                host_ready,
    output logic                host_ack,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                cb_req,
    output logic                cb_we,
    output logic [CFG_AW-1:0]   cb_addr,
    output logic [NBYTE-1:0]    cb_be,
    output logic [DATA_W-1:0]   cb_wdata,
    input  logic                cb_rvalid,
    input  logic [DATA_W-1:0]   cb_rdata
);

    ctrl_state_e         state;
    logic [CFG_AW-1:0]   idx_q;
    logic                accept;
    logic                idx_wr;
    idx_fmt_e            fmt;
    logic [CFG_AW-1:0]   xaddr;
    logic [LANE_W-1:0]   sv_lane;
    xfer_size_e          sv_size;
    logic [LANE_W-1:0]   st_lane;
    xfer_size_e          st_size;
    logic [NBYTE-1:0]    st_be;
    logic [DATA_W-1:0]   st_wdata;
    logic [DATA_W-1:0]   st_rdata;
    cbus_req_t           req_q;

    assign host_ready = (state == ST_IDLE);
    assign accept     = host_req && host_ready;
    assign idx_wr     = accept && !host_sel && host_we;

    cfgx_index_reg #(.W(CFG_AW)) u_idx (
        .clk   (clk),
        .rst   (rst),
        .wr_en (idx_wr),
        .wdata (host_wdata),
        .q     (idx_q)
    );

    cfgx_addr_decode u_dec (
        .idx      (idx_q),
        .off      (host_off),
        .fmt      (fmt),
        .cfg_addr (xaddr)
    );

    // Outgoing lanes use the live request; returning data uses the saved one.
    assign st_lane = (state == ST_WAIT) ? sv_lane : host_off[LANE_W-1:0];
    assign st_size = (state == ST_WAIT) ? sv_size : xfer_size_e'(host_size);

    cfgx_lane_steer #(.DW(DATA_W)) u_lane (
        .size      (st_size),
        .lane      (st_lane),
        .wdata_in  (host_wdata),
        .rdata_in  (cb_rdata),
        .be        (st_be),
        .wdata_out (st_wdata),
        .rdata_out (st_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            host_ack   <= 1'b0;
            host_rdata <= '0;
            cb_req     <= 1'b0;
            req_q      <= '0;
            sv_lane    <= '0;
            sv_size    <= SZ_BYTE;
        end else begin
            host_ack <= 1'b0;
            cb_req   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (!host_sel) begin
                            host_ack <= 1'b1;
                            if (!host_we)
                                host_rdata <= idx_q;
                        end else begin
                            cb_req      <= 1'b1;
                            req_q.we    <= host_we;
                            req_q.addr  <= xaddr;
                            req_q.be    <= st_be;
                            req_q.wdata <= host_we ? st_wdata : '0;
                            sv_lane     <= host_off[LANE_W-1:0];
                            sv_size     <= xfer_size_e'(host_size);
                            if (host_we)
                                host_ack <= 1'b1;
                            else
                                state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (cb_rvalid) begin
                        host_rdata <= st_rdata;
                        host_ack   <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cb_we    = req_q.we;
    assign cb_addr  = req_q.addr;
    assign cb_be    = req_q.be;
    assign cb_wdata = req_q.wdata;

endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker (
    input logic        clk,
    input logic        rst,
    input logic        host_req,
    input logic        host_sel,
    input logic        host_ready,
    input logic        host_ack,
    input logic        cb_req,
    input logic [31:0] cb_addr,
    input logic [3:0]  cb_be,
    input logic        cb_rvalid,
    input logic [31:0] idx
);

    AST_RAW_ADDR: assert property (@(posedge clk) disable iff (rst)
        (cb_req && idx[31]) |-> (cb_addr[31:2] == idx[31:2])); // R2

    AST_TYPE1_ADDR: assert property (@(posedge clk) disable iff (rst)
        (cb_req && !idx[31] && idx[0]) |-> (cb_addr[31:3] == idx[31:3])); // R3

    AST_TYPE0_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (cb_req && !idx[31] && !idx[0]) |->
        (cb_addr[31:16] == 16'h0 && cb_addr[10:3] == idx[10:3])); // R4

    AST_BE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        cb_req |-> (cb_be != 4'b0000)); // R6

    AST_DATA_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_ready && host_sel) |=> cb_req); // R8

    AST_INDEX_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_ready && !host_sel) |=> !cb_req); // R8

    AST_WAIT_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (!host_ready && !cb_rvalid) |=> !host_ack); // R9

    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> host_ready); // R9

endmodule

bind cfg_addr_xlate cfgx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req),
    .host_sel   (host_sel),
    .host_ready (host_ready),
    .host_ack   (host_ack),
    .cb_req     (cb_req),
    .cb_addr    (cb_addr),
    .cb_be      (cb_be),
    .cb_rvalid  (cb_rvalid),
    .idx        (idx_q)
);

// File: tb/cfg_addr_xlate_bench.sv
module cfg_addr_xlate_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_off = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic        cb_req;
    logic        cb_we;
    logic [31:0] cb_addr;
    logic [3:0]  cb_be;
    logic [31:0] cb_wdata;
    logic        cb_rvalid;
    logic [31:0] cb_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cfg_addr_xlate u_cfg_addr_xlate (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_sel(host_sel), .host_we(host_we),
        .host_off(host_off), .host_size(host_size), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_ack(host_ack), .host_rdata(host_rdata),
        .cb_req(cb_req), .cb_we(cb_we), .cb_addr(cb_addr), .cb_be(cb_be),
        .cb_wdata(cb_wdata), .cb_rvalid(cb_rvalid), .cb_rdata(cb_rdata)
    );

    // Target model: a small word array with programmable read latency.
    logic [31:0] mem [0:63];
    int          req_count = 0;
    int          rd_lat = 1;
    int          rd_wait = 0;
    logic [5:0]  rd_slot = '0;
    logic [31:0] last_addr = '0;
    logic [3:0]  last_be = '0;
    logic [31:0] last_wdata = '0;
    logic        last_we = 1'b0;

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        cb_rvalid = 1'b0;
        cb_rdata  = 32'hDEAD_BEEF;
    end

    always @(posedge clk) begin
        cb_rvalid <= 1'b0;
        if (rd_wait != 0) begin
            rd_wait <= rd_wait - 1;
            if (rd_wait == 1) begin
                cb_rvalid <= 1'b1;
                cb_rdata  <= mem[rd_slot];
            end
        end
        if (!rst && cb_req) begin
            req_count  <= req_count + 1;
            last_addr  <= cb_addr;
            last_be    <= cb_be;
            last_wdata <= cb_wdata;
            last_we    <= cb_we;
            if (cb_we) begin
                for (int b = 0; b < 4; b++)
                    if (cb_be[b]) mem[cb_addr[7:2]][8*b +: 8] <= cb_wdata[8*b +: 8];
            end else begin
                rd_slot <= cb_addr[7:2];
                rd_wait <= rd_lat;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_op(input logic sel, input logic we, input logic [2:0] off,
                           input logic [1:0] sz, input logic [31:0] wd,
                           output logic [31:0] rd, output int lat, output int nreq,
                           output logic ready_after);
        int base;
        base = req_count;
        @(negedge clk);
        host_req = 1'b1; host_sel = sel; host_we = we;
        host_off = off; host_size = sz; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        ready_after = host_ready;
        lat = 1;
        while (!host_ack && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        rd = host_rdata;
        @(negedge clk);
        nreq = req_count - base;
    endtask

    task automatic idx_write(input logic [31:0] v);
        logic [31:0] rd; int lat; int n; logic r;
        host_op(1'b0, 1'b1, 3'd0, 2'd2, v, rd, lat, n, r);
    endtask

    task automatic data_write_expect(input string tag, input logic [2:0] off, input logic [1:0] sz,
                                     input logic [31:0] wd, input logic [31:0] exp_addr,
                                     input logic [3:0] exp_be, input logic [31:0] exp_wd);
        logic [31:0] rd; int lat; int n; logic r;
        host_op(1'b1, 1'b1, off, sz, wd, rd, lat, n, r);
        check(last_addr == exp_addr, {tag, " addr"}, last_addr, exp_addr);
        check(last_be == exp_be, {tag, " be R6"}, {28'h0, last_be}, {28'h0, exp_be});
        check(last_wdata == exp_wd, {tag, " wdata R6"}, last_wdata, exp_wd);
        check(n == 1 && last_we, {tag, " one write request R8"}, n, 1);
        check(lat == 1, {tag, " write ack latency R9"}, lat, 1);
    endtask

    task automatic t_reset;
        logic [31:0] rd; int lat; int n; logic r;
        check(host_ready == 1'b1 && host_ack == 1'b0 && cb_req == 1'b0,
              "R1 reset outputs", {29'h0, host_ready, host_ack, cb_req}, 32'h4);
        host_op(1'b0, 1'b0, 3'd0, 2'd2, 32'h0, rd, lat, n, r);
        check(rd == 32'h0, "R1 index reset value", rd, 32'h0);
    endtask

    task automatic t_index;
        logic [31:0] rd; int lat; int n; logic r;
        host_op(1'b0, 1'b1, 3'd1, 2'd0, 32'hA5C3_0F96, rd, lat, n, r);
        check(lat == 1, "R1 index write ack latency", lat, 1);
        check(n == 0, "R8 index write makes no bus request", n, 0);
        host_op(1'b0, 1'b0, 3'd0, 2'd2, 32'h0, rd, lat, n, r);
        check(rd == 32'hA5C3_0F96, "R1 index full-width readback", rd, 32'hA5C3_0F96);
        check(n == 0, "R8 index read makes no bus request", n, 0);
    endtask

    task automatic t_raw;
        idx_write(32'h8001_2347);
        data_write_expect("R2 raw byte", 3'd5, 2'd0, 32'h0000_005A, 32'h8001_2345, 4'b0010, 32'h0000_5A00);
        idx_write(32'h8000_0801);
        data_write_expect("R3 raw beats type1 flag", 3'd2, 2'd1, 32'h0000_1234, 32'h8000_0802, 4'b1100, 32'h1234_0000);
    endtask

    task automatic t_type1;
        idx_write(32'h00AB_CD05);
        data_write_expect("R3 type1 half", 3'd6, 2'd1, 32'h0000_BEEF, 32'h00AB_CD06, 4'b1100, 32'hBEEF_0000);
        idx_write(32'h7FFF_FFFF);
        data_write_expect("R3 type1 word", 3'd0, 2'd2, 32'h0102_0304, 32'h7FFF_FFF8, 4'b1111, 32'h0102_0304);
    endtask

    task automatic t_type0;
        idx_write(32'h0001_0344);
        data_write_expect("R4 type0 dev16 fn3", 3'd0, 2'd2, 32'hCAFE_F00D, 32'h0000_8340, 4'b1111, 32'hCAFE_F00D);
        idx_write(32'h4000_25FC);
        data_write_expect("R4 type0 lowest of many", 3'd3, 2'd0, 32'h0000_0077, 32'h0000_6DFB, 4'b1000, 32'h7700_0000);
        idx_write(32'h4000_0000);
        data_write_expect("R4 type0 dev30", 3'd0, 2'd2, 32'h0, 32'h0000_F000, 4'b1111, 32'h0);
        idx_write(32'h0000_0808);
        data_write_expect("R4 type0 dev11", 3'd1, 2'd0, 32'h0000_0011, 32'h0000_5809, 4'b0010, 32'h0000_1100);
    endtask

    task automatic t_nodev;
        idx_write(32'h0000_0210);
        data_write_expect("R5 no IDSEL bit", 3'd4, 2'd2, 32'h5555_AAAA, 32'h0000_FA14, 4'b1111, 32'h5555_AAAA);
        idx_write(32'h0000_07FA);
        data_write_expect("R5 no IDSEL full fn", 3'd7, 2'd0, 32'h0000_00E1, 32'h0000_FFFF, 4'b1000, 32'hE100_0000);
    endtask

    task automatic t_lanes;
        logic [31:0] rd; int lat; int n; logic r;
        rd_lat = 1;
        idx_write(32'h0000_0001);
        data_write_expect("R6 word store", 3'd0, 2'd2, 32'h1122_3344, 32'h0000_0000, 4'b1111, 32'h1122_3344);
        host_op(1'b1, 1'b0, 3'd2, 2'd0, 32'hFFFF_FFFF, rd, lat, n, r);
        check(rd == 32'h0000_0022, "R7 byte read lane2", rd, 32'h0000_0022);
        check(last_be == 4'b0100 && !last_we, "R6 read byte enables", {28'h0, last_be}, 32'h4);
        check(n == 1, "R8 one read request", n, 1);
        host_op(1'b1, 1'b0, 3'd2, 2'd1, 32'h0, rd, lat, n, r);
        check(rd == 32'h0000_1122, "R7 half read lane2", rd, 32'h0000_1122);
        host_op(1'b1, 1'b0, 3'd1, 2'd0, 32'h0, rd, lat, n, r);
        check(rd == 32'h0000_0033, "R7 byte read lane1", rd, 32'h0000_0033);
        data_write_expect("R6 byte store lane3", 3'd3, 2'd0, 32'hFFFF_FFAA, 32'h0000_0003, 4'b1000, 32'hAA00_0000);
        host_op(1'b1, 1'b0, 3'd0, 2'd3, 32'h0, rd, lat, n, r);
        check(rd == 32'hAA22_3344, "R7 word read after merge", rd, 32'hAA22_3344);
    endtask

    task automatic t_latency;
        logic [31:0] rd; int lat; int n; logic r;
        idx_write(32'h0000_0005);
        data_write_expect("R9 store for latency", 3'd4, 2'd2, 32'h600D_CAFE, 32'h0000_0004, 4'b1111, 32'h600D_CAFE);
        rd_lat = 4;
        host_op(1'b1, 1'b0, 3'd4, 2'd2, 32'h0, rd, lat, n, r);
        check(r == 1'b0, "R9 ready low while read pending", {31'h0, r}, 32'h0);
        check(lat == 7, "R9 read ack after rvalid (lat 4)", lat, 7);
        check(rd == 32'h600D_CAFE, "R7 slow read data", rd, 32'h600D_CAFE);
        check(n == 1, "R8 single request on slow read", n, 1);
        rd_lat = 1;
        host_op(1'b1, 1'b0, 3'd4, 2'd2, 32'h0, rd, lat, n, r);
        check(lat == 4, "R9 read ack after rvalid (lat 1)", lat, 4);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_index();
        t_raw();
        t_type1();
        t_type0();
        t_nodev();
        t_lanes();
        t_latency();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule